// File: doc/BRIEF.md
# Sequential Shift-Accumulate Multiplier

This block multiplies two `W`-bit operands over several clock cycles, adding one partial product per cycle into a `2*W`-bit accumulator. One operand (X) is scanned a bit at a time from its least significant end. The other operand (Y) is gated by that bit, moved into place by a left shift, and added to the running sum. Each operand carries its own signedness flag, so all four combinations of signed and unsigned operands are handled inside the loop itself, with no sign fix-up after it.

A signed Y is sign-extended to the full product width when it is loaded, so every accumulated term carries its sign. A signed X has its top bit weighted by a negative power of two, so the final step subtracts its term instead of adding it. The caller pulses `start` while the block is idle. The block then reports `busy` for `W` cycles, pulses `done` for one cycle, and leaves the product on its output until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes idle: after that edge `busy` = 0, `done` = 0 and `product` = 0. This holds even when a multiplication is under way.
- R2: An accepted start is `start` = 1 at an edge while `busy` = 0. It latches `mul_x`, `mul_y`, `x_signed` and `y_signed`. After that edge, `busy` = 1 and `product` = 0.
- R3: `busy` stays high for exactly `W` (8) cycles after an accepted start. `done` is 1 only in the cycle right after the last busy cycle, lasts exactly one cycle, and is never high together with `busy`.
- R4: With `x_signed` = 0 and `y_signed` = 0, the product in the `done` cycle is the unsigned product of the two operands, `2*W` bits wide.
- R5: With `x_signed` = 0 and `y_signed` = 1, Y is read as two's complement. The product is the low `2*W` bits of the two's-complement result.
- R6: With `x_signed` = 1 and `y_signed` = 0, X is read as two's complement. Its top bit carries weight `-2^(W-1)`.
- R7: With both flags set, the product is the two's-complement product of the two signed operands.
- R8: `start` asserted while `busy` = 1 is ignored. The running operation, its timing and its result do not change.
- R9: After `done`, `product` keeps its value until the next accepted start, and `busy` and `done` stay 0.
- R10: `start` asserted in the same cycle as `done` is accepted. The next operation begins with no idle cycle in between.
- R11: Changes to `mul_x`, `mul_y`, `x_signed` or `y_signed` while `busy` = 1 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; acted on only while idle |
| mul_x | input | W | Operand scanned one bit per cycle |
| mul_y | input | W | Operand gated and accumulated |
| x_signed | input | 1 | 1: `mul_x` is two's complement |
| y_signed | input | 1 | 1: `mul_y` is two's complement |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: `product` is valid |
| product | output | 2*W | Accumulator; holds the result after `done` |

## Verification
The hardest cases to reach from the ports are a second request that lands mid-run, a new request in the exact cycle `done` is high, and a reset in the middle of a run. The bench sweeps every value of one operand against a set of corner values of the other, in all four sign modes. Each operation is started in the `done` cycle of the one before it, so every run is back to back. During each run the bench randomizes the operand and mode inputs. In a directed run it also pulses `start` mid-operation, and it drops reset part way through another run.

// File: rtl/seq_mul_pkg.sv
// Package: seq_mul_pkg
// Holds the types shared by the sequential multiplier's modules.
// Assumes nothing beyond IEEE 1800-2017 packages.
package seq_mul_pkg;

    // The two control states of the multiplier
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;

endpackage

// File: rtl/seq_mul_ctrl.sv
// Module: seq_mul_ctrl
// Sequences one multiplication: it accepts a request while idle, counts W
// accumulate steps, and flags the last step and completion.
// Assumes W >= 2. The reset is synchronous and active low.
module seq_mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic last
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    mul_state_t    state;
    logic [CW-1:0] step_cnt;

    // Decodes the control outputs from the state and the step count
    always_comb begin
        busy = (state == ST_RUN);
        load = (state == ST_IDLE) && start;
        last = busy && (step_cnt == LAST_STEP);
    end

    // Advances the state, the step counter and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        step_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_cnt == LAST_STEP) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step_cnt <= step_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seq_mul_opshift.sv
// Module: seq_mul_opshift
// Holds the two operands for the run. X shifts right so that only its low
// bit is examined. Y is extended to the product width on load and shifts
// left one place per step. Also keeps X's signedness for the final step.
// Assumes load and step are never high together.
module seq_mul_opshift #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   x_in,
    input  logic [W-1:0]   y_in,
    input  logic           x_signed_in,
    input  logic           y_signed_in,
    output logic           x_bit,
    output logic [2*W-1:0] y_aligned,
    output logic           x_is_signed
);
    localparam int PW = 2 * W;

    logic [W-1:0]  x_q;
    logic [PW-1:0] y_q;
    logic          xs_q;
    logic          y_fill;

    // Sign fill for Y: copies its top bit only when Y is signed
    always_comb y_fill = y_signed_in & y_in[W-1];

    // Loads the operands on a request and shifts them on every step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            xs_q <= 1'b0;
        end else if (load) begin
            x_q  <= x_in;
            y_q  <= {{W{y_fill}}, y_in};
            xs_q <= x_signed_in;
        end else if (step) begin
            x_q <= x_q >> 1;
            y_q <= y_q << 1;
        end
    end

    // Presents the examined bit, the aligned multiplicand and the mode
    always_comb begin
        x_bit       = x_q[0];
        y_aligned   = y_q;
        x_is_signed = xs_q;
    end

endmodule

// File: rtl/seq_mul_pp.sv
// Module: seq_mul_pp
// Forms the term for one step: the aligned Y gated by the current X bit.
// On the last step of a signed-X run the term is negated.
// Purely combinational. Assumes y_aligned is already sign-extended.
module seq_mul_pp #(
    parameter int W = 8
) (
    input  logic           x_bit,
    input  logic [2*W-1:0] y_aligned,
    input  logic           last,
    input  logic           x_is_signed,
    output logic [2*W-1:0] term
);
    localparam int PW = 2 * W;

    logic [PW-1:0] gated;
    logic          negate;

    // Gates Y by the X bit and applies the two's-complement negation
    always_comb begin
        gated  = {PW{x_bit}} & y_aligned;
        negate = last & x_is_signed;
        term   = negate ? (~gated + PW'(1)) : gated;
    end

endmodule

// File: rtl/seq_mul_acc.sv
// Module: seq_mul_acc
// Running-sum register: cleared on a new request, adds one term per step,
// and holds otherwise. Its value is the block's product output.
// Assumes load and step are never high together.
module seq_mul_acc #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] term,
    output logic [2*W-1:0] sum
);
    // Clears, accumulates or holds the running sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (load) begin
            sum <= '0;
        end else if (step) begin
            sum <= sum + term;
        end
    end

endmodule

// File: rtl/seq_mul.sv
// Module: seq_mul
// W x W multiplier that adds one partial product per clock. Each operand
// has its own signedness flag. The product is ready W cycles after an
// accepted start, marked by a one-cycle done pulse.
// Assumes a synchronous active-low reset; start is ignored while busy.
module seq_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mul_x,
    input  logic [W-1:0]   mul_y,
    input  logic           x_signed,
    input  logic           y_signed,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic          load;
    logic          last;
    logic          x_bit;
    logic          x_is_signed;
    logic [PW-1:0] y_aligned;
    logic [PW-1:0] term;

    seq_mul_ctrl #(.W(W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .last  (last)
    );

    seq_mul_opshift #(.W(W)) ops_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (busy),
        .x_in        (mul_x),
        .y_in        (mul_y),
        .x_signed_in (x_signed),
        .y_signed_in (y_signed),
        .x_bit       (x_bit),
        .y_aligned   (y_aligned),
        .x_is_signed (x_is_signed)
    );

    seq_mul_pp #(.W(W)) pp_i (
        .x_bit       (x_bit),
        .y_aligned   (y_aligned),
        .last        (last),
        .x_is_signed (x_is_signed),
        .term        (term)
    );

    seq_mul_acc #(.W(W)) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (busy),
        .term  (term),
        .sum   (product)
    );

endmodule

// File: rtl/seq_mul_chk.sv
// Module: seq_mul_chk
// Port-level checker for seq_mul. It records the operands of each accepted
// request, computes the expected product arithmetically and checks the
// handshake timing. Assumes W <= 15 so that products fit in an int.
module seq_mul_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   mul_x,
    input logic [W-1:0]   mul_y,
    input logic           x_signed,
    input logic           y_signed,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    localparam int PW = 2 * W;
    localparam int RW = $clog2(W) + 1;

    logic [PW-1:0] exp_q;
    logic [RW-1:0] run_cnt;

    // Reference product computed with plain integer arithmetic
    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y,
                                              input logic xs, input logic ys);
        int xv;
        int yv;
        int pv;
        xv = xs ? int'($signed(x)) : int'(x);
        yv = ys ? int'($signed(y)) : int'(y);
        pv = xv * yv;
        return pv[PW-1:0];
    endfunction

    // Captures the expected result when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (start && !busy) begin
            exp_q <= ref_mul(mul_x, mul_y, x_signed, y_signed);
        end
    end

    // Counts the busy cycles of the current run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !done && product == '0))
        else $error("R1: block not idle after reset");
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && product == '0))
        else $error("R2: accepted start did not begin a run");
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
        else $error("R3: done longer than one cycle");
    p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy)
        else $error("R3: done together with busy");
    p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_cnt == RW'(W)))
        else $error("R3: run length differs from W");
    // Covers R4, R5, R6 and R7: all four sign modes share this check
    p_product_r4: assert property (@(posedge clk) disable iff (!rst_n) done |-> (product == exp_q))
        else $error("R4: product differs from reference");
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product))
        else $error("R9: product changed while idle");

endmodule

bind seq_mul seq_mul_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mul_x    (mul_x),
    .mul_y    (mul_y),
    .x_signed (x_signed),
    .y_signed (y_signed),
    .busy     (busy),
    .done     (done),
    .product  (product)
);

// File: tb/seq_mul_tb_top.sv
// Bench for seq_mul. It sweeps one operand over all values against corner
// values of the other, in all four sign modes, running every operation back
// to back, and adds directed handshake and reset cases.
module seq_mul_tb_top;
    localparam int W          = 8;
    localparam int PW         = 2 * W;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [W-1:0]  mul_x;
    logic [W-1:0]  mul_y;
    logic          x_signed;
    logic          y_signed;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    seq_mul #(.W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mul_x    (mul_x),
        .mul_y    (mul_y),
        .x_signed (x_signed),
        .y_signed (y_signed),
        .busy     (busy),
        .done     (done),
        .product  (product)
    );

    // Free-running clock
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Records one check and reports a failure
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference product from integer arithmetic
    function automatic logic [PW-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input bit xs, input bit ys);
        int xv;
        int yv;
        int pv;
        xv = xs ? int'($signed(x)) : int'(x);
        yv = ys ? int'($signed(y)) : int'(y);
        pv = xv * yv;
        return pv[PW-1:0];
    endfunction

    // Requirement tag for a sign mode
    function automatic string mode_tag(input bit xs, input bit ys);
        if (!xs && !ys) return "R4 unsigned";
        if (!xs && ys)  return "R5 y signed";
        if (xs && !ys)  return "R6 x signed";
        return "R7 both signed";
    endfunction

    // Puts random values on the operand and mode inputs
    task automatic scramble();
        mul_x    = W'($urandom);
        mul_y    = W'($urandom);
        x_signed = 1'($urandom);
        y_signed = 1'($urandom);
    endtask

    // One full operation. Entered and left at a falling edge; leaving in
    // the done cycle, so the next call starts back to back.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input bit xs, input bit ys);
        logic [PW-1:0] exp;
        exp      = model(x, y, xs, ys);
        mul_x    = x;
        mul_y    = y;
        x_signed = xs;
        y_signed = ys;
        start    = 1'b1;
        @(negedge clk);
        check(busy && !done && product == '0, "R2/R10 start accepted, product cleared",
              {done, busy, 14'b0, product}, 32'h4000_0000);
        start = 1'b0;
        scramble();  // R11: inputs change while busy
        repeat (W) @(negedge clk);
        check(done && !busy && product == exp, mode_tag(xs, ys), {done, busy, 14'b0, product},
              {2'b10, 14'b0, exp});
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // Main stimulus
    initial begin
        logic [W-1:0]  corners [6];
        logic [PW-1:0] exp;
        corners = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
        rst_n    = 1'b0;
        start    = 1'b0;
        mul_x    = '0;
        mul_y    = '0;
        x_signed = 1'b0;
        y_signed = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset state", {done, busy, 14'b0, product}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed run: timing, a mid-run start and changing inputs
        exp      = model(8'hB3, 8'h6D, 1'b1, 1'b1);
        mul_x    = 8'hB3;
        mul_y    = 8'h6D;
        x_signed = 1'b1;
        y_signed = 1'b1;
        start    = 1'b1;
        @(negedge clk);
        check(busy && product == '0, "R2 busy after start", {busy, 15'b0, product}, 32'h8000_0000);
        start = 1'b0;
        scramble();
        @(negedge clk);
        start = 1'b1;  // R8: request while busy
        mul_x = 8'h11;
        mul_y = 8'h22;
        @(negedge clk);
        start = 1'b0;
        repeat (W - 3) @(negedge clk);
        check(busy && !done, "R3 still busy in last step", {done, busy}, 32'h1);
        start = 1'b1;  // R8: request during the last busy cycle
        @(negedge clk);
        start = 1'b0;
        check(done && !busy, "R3 done after W busy cycles", {done, busy}, 32'h2);
        check(product == exp, "R8/R11 result unaffected", product, exp);
        @(negedge clk);
        check(!done && !busy, "R3/R8 done one cycle, late start ignored", {done, busy}, 0);
        scramble();
        repeat (5) @(negedge clk);
        check(product == exp && !busy && !done, "R9 product held while idle", product, exp);

        // A new start clears the held nonzero product
        run_op(8'hFF, 8'hFF, 1'b0, 1'b0);
        @(negedge clk);

        // Reset in the middle of a run
        mul_x    = 8'h9C;
        mul_y    = 8'hE7;
        x_signed = 1'b0;
        y_signed = 1'b1;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset mid-run", {done, busy, 14'b0, product}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: every value against corners, all modes, back to back (R10)
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 256; v++) begin
                for (int c = 0; c < 6; c++) begin
                    run_op(W'(v), corners[c], m[1], m[0]);
                    run_op(corners[c], W'(v), m[1], m[0]);
                end
            end
        end
        @(negedge clk);
        check(!done && !busy, "R3 done clears after final run", {done, busy}, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule